// File: doc/BRIEF.md
# Masked Eight-Line Interrupt Controller

This block collects up to eight interrupt requests in a pending register and drives one interrupt line towards a system-level interrupt aggregator. Hardware sources change the pending register with two bit vectors, one that raises bits and one that drops them. Software reaches the block through a byte-wide register port. Through that port it programs an enable mask, retires single pending bits by writing their index, and reads the pending byte back.

The mask is written in inverted sense: a 1 written to a bit position disables that line. The interrupt output is a registered flag that follows whether any pending bit is also enabled. It is recomputed on every cycle in which the mask, the sources or an acknowledge changes. A second controller position is present only as a stub. It keeps its mask byte, reads as zero, and ignores acknowledges.

The read port is combinational and 64 bits wide. A byte access uses the low eight bits. A wide access of the same address sees the same byte with zeros above it.

Top module: `irq_mask_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pending register and the interrupt flag are cleared and the enable set becomes all zeros, so every line is masked; after reset `irq_out` is 0 and a status read returns 0.
- R2: A write to address 1 (primary mask) stores the bitwise inverse of `reg_wdata` as the enable set, so a written 1 disables that line and a written 0 enables it.
- R3: `irq_out` is 1 exactly when the bitwise AND of the pending register and the enable set is nonzero, and it takes the value that follows from the inputs sampled at a clock edge right after that edge.
- R4: A write to address 2 (primary acknowledge) clears the pending bit whose index is `reg_wdata[3:0]`; bits 7:4 of the data are ignored and indices 8 to 15 change nothing.
- R5: Every bit set in `src_set` becomes 1 in the pending register, and every bit set in `src_clr` becomes 0, at the same clock edge.
- R6: When a bit is raised by `src_set` in the same cycle in which it is acknowledged or named in `src_clr`, the raise wins and the bit ends up pending.
- R7: With `reg_addr` equal to 0 (primary status), `reg_rdata` shows the current pending byte in bits 7:0 and zeros in bits 63:8, in the same cycle and with no side effect.
- R8: The secondary controller reads 0 at address 4 (status), and writes to address 5 (its mask) and address 6 (its acknowledge) leave the pending register and `irq_out` unchanged.
- R9: Reads of addresses 1, 2, 3, 5, 6 and 7 return 0, and writes to addresses 0, 3 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 64 | Combinational read data, zero-extended byte |
| src_set | input | 8 | Per-line request raise vector from hardware sources |
| src_clr | input | 8 | Per-line request drop vector from hardware sources |
| irq_out | output | 1 | Interrupt to the system aggregator |

## Verification
On every cycle, the assertions check four things: the registered interrupt flag agrees with the pending and enable registers, a mask write lands inverted, raised bits stick over clears and acknowledges, and an acknowledge produces at most one clear. The secondary mask storage is also checked this way. Other behaviour shows only in the bench's scenarios. These cover the inverted-mask sweep across every mask byte against many pending patterns, out-of-range acknowledge indices with junk upper bits, and the fact that secondary and unmapped accesses leave the status byte and the output untouched.

// File: rtl/irq_mask_ctrl_pkg.sv
// Package: shared sizes and register addresses of the masked interrupt controller.
// Assumes one controller of LINES request lines reached through a byte port.
package irq_mask_ctrl_pkg;
    localparam int LINES   = 8;
    localparam int ADDR_W  = 3;
    localparam int WIDE_W  = 64;
    localparam int IDX_W   = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_PRI_STAT = 3'd0,
        A_PRI_MASK = 3'd1,
        A_PRI_ACK  = 3'd2,
        A_SEC_STAT = 3'd4,
        A_SEC_MASK = 3'd5,
        A_SEC_ACK  = 3'd6
    } reg_addr_e;
endpackage

// File: rtl/imc_regport.sv
// Register port decoder: turns byte writes into strobes and a one-hot
// acknowledge vector, and multiplexes the zero-extended read data.
// Assumes at most one write per cycle; reads have no side effects.
module imc_regport
    import irq_mask_ctrl_pkg::*;
#(
    parameter int N      = LINES,
    parameter int AW     = ADDR_W,
    parameter int RW     = WIDE_W,
    parameter int IW     = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [N-1:0]  wdata,
    input  logic [N-1:0]  pend,
    output logic          pri_mask_we,
    output logic          sec_mask_we,
    output logic [N-1:0]  ack_vec,
    output logic [RW-1:0] rdata
);
    localparam int PAD_W = RW - N;

    logic          pri_ack_we;
    logic [IW-1:0] ack_idx;

    // Decode the write strobes from the address.
    always_comb begin
        pri_mask_we = wr_en && (addr == AW'(A_PRI_MASK));
        sec_mask_we = wr_en && (addr == AW'(A_SEC_MASK));
        pri_ack_we  = wr_en && (addr == AW'(A_PRI_ACK));
        ack_idx     = wdata[IW-1:0];
    end

    // One clear line per request line; indices past the last line match nothing.
    for (genvar i = 0; i < N; i++) begin : g_ack
        assign ack_vec[i] = pri_ack_we && (ack_idx == IW'(i));
    end

    // Read mux: only the primary status address returns data.
    always_comb begin
        if (addr == AW'(A_PRI_STAT)) rdata = {{PAD_W{1'b0}}, pend};
        else                         rdata = '0;
    end

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_vec)); // R4
endmodule

// File: rtl/imc_pending.sv
// Pending register: sources raise and drop bits, acknowledges drop single
// bits, and a raise wins over any drop of the same bit in the same cycle.
// Assumes all inputs are synchronous to clk.
module imc_pending #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    input  logic [N-1:0] ack_vec,
    output logic [N-1:0] pend_d,
    output logic [N-1:0] pend_q
);
    // Next pending value: drops first, then raises override.
    always_comb begin
        pend_d = (pend_q & ~(clr_vec | ack_vec)) | set_vec;
    end

    // Hold the pending bits; reset empties them.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend_q & $past(set_vec)) == $past(set_vec))); // R6
    AST_DROP_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend_q & $past(clr_vec | ack_vec) & ~$past(set_vec)) == '0)); // R5
endmodule

// File: rtl/imc_gate.sv
// Enable gate: keeps the enable set written in inverted sense and the
// registered interrupting flag that follows (pending AND enable).
// Assumes pend_d is the pending value that lands at the same edge.
module imc_gate #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_we,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] pend_d,
    input  logic [N-1:0] pend_q,
    output logic         irq_q
);
    logic [N-1:0] en_q;
    logic [N-1:0] en_d;

    // Next enable set: a mask write stores the inverted byte.
    always_comb begin
        en_d = mask_we ? ~wdata : en_q;
    end

    // Hold the enable set; reset masks every line.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    // Interrupting flag, recomputed from the values that land at this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(pend_d & en_d);
    end

    AST_MASK_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(mask_we) |-> (en_q == ~$past(wdata))); // R2
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == |(pend_q & en_q)); // R3
endmodule

// File: rtl/imc_sec_stub.sv
// Secondary controller stub: stores its mask byte and nothing else.
// Assumes the stored byte drives no logic.
module imc_sec_stub #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_we,
    input  logic [N-1:0] wdata
);
    logic [N-1:0] sec_mask_q;

    // Keep the last written secondary mask.
    always_ff @(posedge clk) begin
        if (!rst_n)       sec_mask_q <= '0;
        else if (mask_we) sec_mask_q <= wdata;
    end

    AST_SEC_MASK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(mask_we) |-> (sec_mask_q == $past(wdata))); // R8
endmodule

// File: rtl/irq_mask_ctrl.sv
// Top of the masked interrupt controller: register port, pending register,
// enable gate and secondary stub. Assumes a synchronous active-low reset.
module irq_mask_ctrl
    import irq_mask_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [LINES-1:0]  reg_wdata,
    output logic [WIDE_W-1:0] reg_rdata,
    input  logic [LINES-1:0]  src_set,
    input  logic [LINES-1:0]  src_clr,
    output logic              irq_out
);
    logic             pri_mask_we;
    logic             sec_mask_we;
    logic [LINES-1:0] ack_vec;
    logic [LINES-1:0] pend_d;
    logic [LINES-1:0] pend_q;

    imc_regport #(.N(LINES), .AW(ADDR_W), .RW(WIDE_W), .IW(IDX_W)) u_regport (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .pend        (pend_q),
        .pri_mask_we (pri_mask_we),
        .sec_mask_we (sec_mask_we),
        .ack_vec     (ack_vec),
        .rdata       (reg_rdata)
    );

    imc_pending #(.N(LINES)) u_pending (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (src_set),
        .clr_vec (src_clr),
        .ack_vec (ack_vec),
        .pend_d  (pend_d),
        .pend_q  (pend_q)
    );

    imc_gate #(.N(LINES)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (pri_mask_we),
        .wdata   (reg_wdata),
        .pend_d  (pend_d),
        .pend_q  (pend_q),
        .irq_q   (irq_out)
    );

    imc_sec_stub #(.N(LINES)) u_sec (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (sec_mask_we),
        .wdata   (reg_wdata)
    );

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pend_q == '0) && !irq_out); // R1
endmodule

// File: tb/irq_mask_ctrl_bench.sv
`timescale 1ns/1ps
module irq_mask_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [7:0]  src_set = '0;
    logic [7:0]  src_clr = '0;
    logic        irq_out;

    int total = 0;
    int bad = 0;
    logic [7:0] m_pend = '0;
    logic [7:0] m_en = '0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_mask_ctrl u_irq_mask_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_set(src_set),
        .src_clr(src_clr), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, update the model, release inputs.
    task automatic cyc(input logic wr, input logic [2:0] a, input logic [7:0] d,
                       input logic [7:0] s, input logic [7:0] c);
        logic [7:0] ackm;
        @(negedge clk);
        reg_wr_en = wr; reg_addr = a; reg_wdata = d; src_set = s; src_clr = c;
        @(posedge clk);
        #1;
        ackm = (wr && a == 3'd2 && d[3:0] < 4'd8) ? (8'd1 << d[3:0]) : 8'd0;
        if (wr && a == 3'd1) m_en = ~d;
        m_pend = (m_pend & ~(ackm | c)) | s;
        reg_wr_en = 1'b0; reg_addr = 3'd0; reg_wdata = '0; src_set = '0; src_clr = '0;
    endtask

    // Read status and output against the model.
    task automatic observe(input string req);
        reg_addr = 3'd0;
        #0.5;
        check(req, reg_rdata, {56'd0, m_pend});
        check(req, {63'd0, irq_out}, {63'd0, |(m_pend & m_en)});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 status", reg_rdata, 64'd0);
        check("R1 irq", {63'd0, irq_out}, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset leaves lines masked; raising everything gives no irq.
        cyc(0, 0, 0, 8'hFF, 0);
        check("R1 masked after reset", {63'd0, irq_out}, 64'd0);
        observe("R1");
        // R2 R3 R7: sweep all masks against spread pending patterns.
        for (int m = 0; m < 256; m++) begin
            for (int p = 0; p < 256; p += 17) begin
                cyc(0, 0, 0, 8'(p), 8'hFF);
                cyc(1, 1, 8'(m), 0, 0);
                observe("R2 R3 R7 sweep");
            end
        end
        // R4: acknowledge each index with junk upper nibble.
        cyc(1, 1, 8'h00, 0, 0);
        for (int i = 0; i < 16; i++) begin
            cyc(0, 0, 0, 8'hFF, 0);
            cyc(1, 2, 8'((i * 16 + 32) & 8'hF0) | 8'(i), 0, 0);
            observe("R4 ack index");
        end
        // R4: ack the last set line drops irq.
        cyc(0, 0, 0, 8'hFF, 0);
        cyc(1, 1, 8'hFB, 0, 0);
        cyc(1, 2, 8'h02, 0, 0);
        check("R4 irq drops", {63'd0, irq_out}, 64'd0);
        // R5: set and clear vectors.
        cyc(1, 1, 8'h00, 0, 0);
        cyc(0, 0, 0, 0, 8'hFF);
        cyc(0, 0, 0, 8'hA5, 0);
        observe("R5 set");
        cyc(0, 0, 0, 8'h0C, 8'h21);
        observe("R5 set and clear");
        cyc(0, 0, 0, 0, 8'hFF);
        observe("R5 clear all");
        // R6: raise wins over ack and over clear.
        cyc(1, 2, 8'h03, 8'h08, 0);
        observe("R6 set beats ack");
        check("R6 bit3", {63'd0, reg_rdata[3]}, 64'd1);
        cyc(0, 0, 0, 8'h10, 8'h10);
        observe("R6 set beats clear");
        // R8: secondary accesses.
        cyc(0, 0, 0, 8'h41, 0);
        cyc(1, 1, 8'hBE, 0, 0);
        observe("R8 before");
        cyc(1, 5, 8'hFF, 0, 0);
        observe("R8 sec mask");
        cyc(1, 6, 8'h00, 0, 0);
        cyc(1, 6, 8'h06, 0, 0);
        observe("R8 sec ack");
        reg_addr = 3'd4; #0.5;
        check("R8 sec read", reg_rdata, 64'd0);
        // R9: other addresses.
        for (int a = 1; a < 8; a++) begin
            if (a != 4) begin
                @(negedge clk); reg_addr = 3'(a); #0.5;
                check("R9 read zero", reg_rdata, 64'd0);
            end
        end
        cyc(1, 0, 8'h00, 0, 0);
        cyc(1, 3, 8'hFF, 0, 0);
        cyc(1, 7, 8'h01, 0, 0);
        observe("R9 writes ignored");
        check("R9 irq kept", {63'd0, irq_out}, 64'd1);
        // R1: reset in the middle.
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        m_pend = '0; m_en = '0;
        observe("R1 mid reset");
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule